// File: doc/BRIEF.md
# Aligning Single-Pattern Byte Matcher

This block searches a byte stream for one fixed pattern of `SEG_N * LANES` bytes. The pattern is split into `SEG_N` segments of `LANES` bytes. Each segment is held by one process element that owns exactly `LANES` byte comparators. A process element compares its segment only against the current aligned window, which is the `LANES` oldest unconsumed bytes.

An enable token moves down the element chain on each successful step. The first element is always enabled. When the token reaches the last element and that element matches, the block reports a match. It gives the stream index of the pattern's first byte.

Occurrences that do not start on a window boundary are caught by an alignment element in front of the first segment. It tests every proper suffix of the window against the same-length prefix of the first segment. A shift encoder then advances the read pointer by `LANES` minus the longest matching suffix length. In the next step the candidate sits at the window start. Each such partial hit costs one extra step.

Input arrives as beats of `LANES` bytes under a valid/ready handshake. A small skid buffer of `2*LANES-1` bytes feeds the window.

Top module: `pattern_aligner`

## Requirements
- R1: While reset is held and in the cycle after it is released, `in_ready` is 1 and `match_o` is 0. The byte index count starts at 0 for the first accepted byte.
- R2: An occurrence whose first byte is at the window start is reported. A step in which any enabled process element fully matches advances the pointer by exactly `LANES` bytes.
- R3: When no process element matches, the pointer advance is `LANES` minus the longest window suffix that equals a prefix of the first segment. With no such suffix the advance is `LANES`. An occurrence starting at any window offset is reported.
- R4: A match is reported by `match_o` high for a single cycle. `match_idx` then holds the stream index of the pattern's first byte. Stream bytes are numbered from 0 in arrival order, and beat lane 0 (`in_data[7:0]`) is the earliest byte of a beat.
- R5: `in_ready` is high exactly when fewer than `LANES` buffered bytes remain after the current cycle's advance. The buffer never holds more than `2*LANES-1` bytes. A stream held valid that contains no byte equal to the pattern's first byte is accepted every cycle.
- R6: A chain that matched some leading segments and then mismatches reports nothing. An occurrence that starts inside the mismatching window is still found.
- R7: For a pattern whose bytes are all distinct, every occurrence is reported exactly once, in stream order. This includes back-to-back occurrences, and the result does not depend on idle cycles between beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 8*LANES | Input beat, lane 0 in bits [7:0] is the earliest byte |
| in_ready | output | 1 | Block accepts a beat this cycle |
| match_o | output | 1 | One-cycle pulse on a completed match |
| match_idx | output | IDX_W | Stream index of the first byte of the match |

## Verification
A realignment step and a chain step can fall in the same cycle. A window that fails the second segment while ending in the first segment's leading bytes must drop the chain and shorten the advance together. Streams such as "zzabcdabcdef" and "abcdeabcdef" provoke this. The bench judges them by the reported start index, which must equal the brute-force position, and by the absence of any extra pulse. Randomised streams with idle gaps mix these collisions with back-to-back occurrences and are judged the same way through a queue of expected indices.

// File: rtl/pm_pkg.sv
// Package: shared constants for the aligning pattern matcher.
// Assumes byte-oriented streams.
package pm_pkg;
    localparam int CHAR_W = 8;
endpackage

// File: rtl/pm_window_buf.sv
// Skid buffer feeding the comparison window.
// Holds up to 2*LANES-1 bytes, oldest byte in the low lane. Presents the
// LANES oldest bytes as the window and drops ADV bytes each step.
// Assumes bytes above the fill level are kept at zero (invariant kept here).
module pm_window_buf
    import pm_pkg::*;
#(
    parameter int LANES  = 3,
    parameter int CNT_W  = 3,
    parameter int ADV_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [CHAR_W*LANES-1:0]   in_data,
    output logic                      in_ready,
    input  logic [ADV_W-1:0]          adv,
    output logic                      win_ok,
    output logic [CHAR_W*LANES-1:0]   window
);
    localparam int DEPTH = 2 * LANES - 1;
    localparam int BUF_W = CHAR_W * DEPTH;

    logic [BUF_W-1:0] store_q, store_d;
    logic [CNT_W-1:0] fill_q, fill_d;
    logic [CNT_W-1:0] drop;
    logic [CNT_W-1:0] left;
    logic             take;

    // Work out whether a step happens and how many bytes survive it.
    always_comb begin
        win_ok = (fill_q >= CNT_W'(LANES));
        drop   = win_ok ? CNT_W'(adv) : '0;
        left   = fill_q - drop;
    end

    assign in_ready = (left < CNT_W'(LANES));
    assign take     = in_valid && in_ready;
    assign window   = store_q[CHAR_W*LANES-1:0];

    // Shift out consumed bytes and append an accepted beat behind the rest.
    always_comb begin
        store_d = store_q >> {drop, 3'b000};
        if (take) begin
            store_d = store_d | (BUF_W'(in_data) << {left, 3'b000});
        end
        fill_d = left + (take ? CNT_W'(LANES) : '0);
    end

    // Register buffer contents and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
            fill_q  <= '0;
        end else begin
            store_q <= store_d;
            fill_q  <= fill_d;
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CNT_W'(DEPTH));

    assert_accept_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (fill_q >= CNT_W'(LANES)));
endmodule

// File: rtl/pm_proc_elem.sv
// Process element: one pattern segment of LANES bytes.
// Uses exactly LANES byte comparators, all against the aligned window.
// Assumes its enable comes from the previous element's registered result.
module pm_proc_elem
    import pm_pkg::*;
#(
    parameter int                          LANES = 3,
    parameter logic [CHAR_W*LANES-1:0]     SEG   = '0
) (
    input  logic [CHAR_W*LANES-1:0] window,
    input  logic                    en_in,
    output logic                    hit
);
    logic [LANES-1:0] lane_eq;

    // One comparator per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_cmp
        assign lane_eq[i] = (window[CHAR_W*i +: CHAR_W] == SEG[CHAR_W*i +: CHAR_W]);
    end

    // Full segment match gated by the incoming enable.
    assign hit = en_in & (&lane_eq);
endmodule

// File: rtl/pm_align_elem.sv
// Alignment element for the first segment.
// For each length s in 1..LANES-1 it tests the last s window bytes against
// the first s segment bytes, LANES*(LANES-1)/2 comparators in total.
// Assumes LANES >= 2.
module pm_align_elem
    import pm_pkg::*;
#(
    parameter int                          LANES = 3,
    parameter logic [CHAR_W*LANES-1:0]     SEG0  = '0
) (
    input  logic [CHAR_W*LANES-1:0] window,
    output logic [LANES-1:1]        sfx_hit
);
    // One comparator set per suffix length.
    for (genvar s = 1; s < LANES; s++) begin : g_sfx
        assign sfx_hit[s] =
            (window[CHAR_W*(LANES-s) +: CHAR_W*s] == SEG0[0 +: CHAR_W*s]);
    end
endmodule

// File: rtl/pm_shift_enc.sv
// Shift encoder: turns suffix hits and the chain result into a pointer
// advance. A full segment hit wins and gives LANES. Otherwise the longest
// suffix hit s gives LANES - s, and no hit gives LANES.
// Assumes LANES >= 2.
module pm_shift_enc #(
    parameter int LANES = 3,
    parameter int ADV_W = 2
) (
    input  logic [LANES-1:1]  sfx_hit,
    input  logic              full_hit,
    output logic [ADV_W-1:0]  adv
);
    logic [ADV_W-1:0] sfx_len;

    // Priority pick of the longest suffix, then the advance.
    always_comb begin
        sfx_len = '0;
        for (int s = 1; s < LANES; s++) begin
            if (sfx_hit[s]) sfx_len = ADV_W'(s);
        end
        adv = full_hit ? ADV_W'(LANES) : (ADV_W'(LANES) - sfx_len);
    end
endmodule

// File: rtl/pattern_aligner.sv
// Top: single-pattern matcher with a process-element chain, an alignment
// element and a shift encoder. PATTERN byte 0 sits in bits [7:0].
// Assumes LANES >= 2 and SEG_N >= 2. Every occurrence is found when the
// pattern bytes are all distinct.
module pattern_aligner
    import pm_pkg::*;
#(
    parameter int                                  LANES   = 3,
    parameter int                                  SEG_N   = 2,
    parameter int                                  IDX_W   = 32,
    parameter logic [CHAR_W*LANES*SEG_N-1:0]       PATTERN = 48'h666564636261
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [CHAR_W*LANES-1:0]   in_data,
    output logic                      in_ready,
    output logic                      match_o,
    output logic [IDX_W-1:0]          match_idx
);
    localparam int PAT_LEN = LANES * SEG_N;
    localparam int CNT_W   = $clog2(2 * LANES);
    localparam int ADV_W   = $clog2(LANES + 1);
    localparam int BACK    = PAT_LEN - LANES;

    logic [CHAR_W*LANES-1:0] window;
    logic                    step;
    logic [ADV_W-1:0]        adv;
    logic [LANES-1:1]        sfx_hit;
    logic [SEG_N-1:0]        seg_en;
    logic [SEG_N-1:0]        seg_hit;
    logic [SEG_N-1:1]        token_q;
    logic [IDX_W-1:0]        base_q;

    pm_window_buf #(.LANES(LANES), .CNT_W(CNT_W), .ADV_W(ADV_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .adv      (adv),
        .win_ok   (step),
        .window   (window)
    );

    // First element is always enabled; later ones take the passed token.
    assign seg_en = {token_q, 1'b1};

    for (genvar j = 0; j < SEG_N; j++) begin : g_pe
        pm_proc_elem #(
            .LANES (LANES),
            .SEG   (PATTERN[CHAR_W*LANES*j +: CHAR_W*LANES])
        ) u_pe (
            .window (window),
            .en_in  (seg_en[j]),
            .hit    (seg_hit[j])
        );
    end

    pm_align_elem #(.LANES(LANES), .SEG0(PATTERN[CHAR_W*LANES-1:0])) u_align (
        .window  (window),
        .sfx_hit (sfx_hit)
    );

    pm_shift_enc #(.LANES(LANES), .ADV_W(ADV_W)) u_enc (
        .sfx_hit  (sfx_hit),
        .full_hit (|seg_hit),
        .adv      (adv)
    );

    // Pass tokens, track the window's stream index and raise the match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            token_q   <= '0;
            base_q    <= '0;
            match_o   <= 1'b0;
            match_idx <= '0;
        end else begin
            match_o <= 1'b0;
            if (step) begin
                token_q <= seg_hit[SEG_N-2:0];
                base_q  <= base_q + IDX_W'(adv);
                if (seg_hit[SEG_N-1]) begin
                    match_o   <= 1'b1;
                    match_idx <= base_q - IDX_W'(BACK);
                end
            end
        end
    end

    assert_full_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (|seg_hit)) |-> (adv == ADV_W'(LANES)));

    assert_adv_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ((adv >= ADV_W'(1)) && (adv <= ADV_W'(LANES))));

    assert_no_sfx_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(|seg_hit) && !(|sfx_hit)) |-> (adv == ADV_W'(LANES)));
endmodule

// File: tb/tb_pattern_aligner.sv
module tb_pattern_aligner;
    localparam int LANES = 3;
    localparam int SEG_N = 2;
    localparam int PLEN  = LANES * SEG_N;
    localparam logic [8*PLEN-1:0] PAT = 48'h666564636261;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [8*LANES-1:0] in_data;
    logic              in_ready;
    logic              match_o;
    logic [31:0]       match_idx;

    always #2 clk = ~clk;

    pattern_aligner #(.LANES(LANES), .SEG_N(SEG_N), .IDX_W(32), .PATTERN(PAT)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .match_o(match_o), .match_idx(match_idx)
    );

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic [7:0] stream[$];
    int sent = 0;
    bit rate_watch = 1'b0;
    int rate_stalls = 0;
    string cur_tag = "R4";
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic add_str(input string s);
        for (int i = 0; i < s.len(); i++) stream.push_back(s[i]);
    endtask

    function automatic bit pat_at(input int q);
        for (int i = 0; i < PLEN; i++)
            if (stream[q+i] != PAT[8*i +: 8]) return 1'b0;
        return 1'b1;
    endfunction

    // Driver: pads, predicts matches by brute force, sends beats.
    task automatic run_stream(input string tag, input bit gaps);
        int nbeats;
        cur_tag = tag;
        while (stream.size() % LANES != 0) stream.push_back("z");
        for (int i = 0; i < 2*LANES; i++) stream.push_back("z");
        for (int q = 0; q + PLEN <= stream.size(); q++)
            if (pat_at(q)) exp_q.push_back(sent + q);
        nbeats = stream.size() / LANES;
        @(negedge clk);
        for (int b = 0; b < nbeats; b++) begin
            if (gaps && $urandom_range(0, 2) == 0) begin
                in_valid = 1'b0;
                repeat ($urandom_range(1, 3)) @(negedge clk);
            end
            in_valid = 1'b1;
            for (int i = 0; i < LANES; i++) in_data[8*i +: 8] = stream[b*LANES + i];
            while (!in_ready) begin
                if (rate_watch) rate_stalls++;
                @(negedge clk);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        sent += stream.size();
        stream.delete();
        repeat (25) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " missing matches"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Monitor: pops the expected start index on every match pulse.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && match_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected match", int'(match_idx), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(match_idx) == e, {cur_tag, " R4 start index"}, int'(match_idx), e);
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        string alpha;
        alpha = "abcdefz";
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = '0;
        repeat (4) @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
        chk(match_o == 1'b0, "R1 match in reset", match_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        chk(match_o == 1'b0, "R1 match after reset", match_o, 0);

        // R5: no pattern-start byte, full rate
        rate_watch = 1'b1;
        for (int i = 0; i < 90; i++) stream.push_back(alpha[$urandom_range(1, 6)]);
        run_stream("R5 clean stream", 1'b0);
        rate_watch = 1'b0;
        chk(rate_stalls == 0, "R5 stalls on clean stream", rate_stalls, 0);

        // R2: aligned occurrence
        add_str("abcdef");
        run_stream("R2 aligned", 1'b0);

        // R3: offsets 1 and 2
        add_str("zabcdef");
        run_stream("R3 offset1", 1'b0);
        add_str("zzabcdef");
        run_stream("R3 offset2", 1'b0);

        // R6: broken chains with restarts inside the failing window
        add_str("abcabcdef");
        run_stream("R6 restart full", 1'b0);
        add_str("zzabcdabcdef");
        run_stream("R6 restart suffix2", 1'b0);
        add_str("abcdeabcdef");
        run_stream("R6 restart suffix1", 1'b0);
        add_str("abczzzabcdez");
        run_stream("R6 no match", 1'b0);

        // R7: back-to-back and random with gaps
        add_str("abcdefabcdefzabcdefabcdef");
        run_stream("R7 back to back", 1'b0);
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 200; i++) begin
                if ($urandom_range(0, 7) == 0) add_str("abcdef");
                else stream.push_back(alpha[$urandom_range(0, 6)]);
            end
            run_stream("R7 random gaps", 1'b1);
        end

        report();
    end
endmodule